// File: doc/BRIEF.md
# Programmable PWM Ramp Sequencer

This block drives three pulse-width-modulated outputs. Each channel compares a shared 8-bit free-running counter with its own 8-bit brightness level. It does not set that level through a plain compare register. Instead, each channel runs a short program of 16-bit instructions from its own program memory. The instructions can set the level at once, force it to an end point, step it up or down at a programmable rate, restart the program, branch within it, or do nothing.

A host fills each program memory through one byte-wide port per channel. For each word it writes the high byte and then the low byte. A shared control register turns channels on and off. Disabling a channel freezes it and rewinds its program. Enabling it runs the program from the first word. The program memory keeps its contents across disable and enable. The counter advances on an external tick strobe, nominally 32768 Hz. Ramp step intervals are also measured in these ticks, either one by one or through a divide-by-512 prescaler.

Top module: `pwm_ramp_engine`

## Requirements
- R1: Writing address 0 loads the control register. Bit i (0, 1, 2) enables channel i. A disabled channel's output is low, and each bit affects only its own channel.
- R2: The 8-bit counter advances by one on every clock with `pwm_tick` high and wraps from 0xFF to 0x00. An enabled channel is high when counter >= level, except that level 0xFF keeps it low. Over 256 ticks, level L gives 256-L high cycles for L < 0xFF and 0 for L = 0xFF.
- R3: Address 1+i is the program port of channel i. The first byte of a pair is the high byte and the second is the low byte. The second byte stores the word and advances the word pointer. Any control write clears every pointer and byte phase. Words never written read as 0x0000.
- R4: Word 0x0000 sets the program counter to 0.
- R5: Word 0x007F sets the level to 0xFF (output inactive). Word 0x00FF sets the level to 0x00 (output always active). Both advance the program counter.
- R6: A word with bit 15 = 0, bit 14 = 1 and bits 13:8 = 0 is a load. Bits 7:0 become the level on the clock that executes it.
- R7: Any other word with bit 15 = 0 is a ramp, apart from the codes in R4 and R5. It has a step count in bits 6:0 and a direction in bit 7 (1 = down). The step time in bits 13:8 is read as 1 when it is 0. Bit 14 selects a x512 prescaler. The level moves by one per interval of steptime x (512 or 1) ticks. The next word runs on the clock after the last step. A step count of 0 acts as no-op.
- R8: A ramp holds the level at 0x00 going down and at 0xFF going up, and still uses up its steps.
- R9: A word with bits 15 and 13 both set is a branch to the word address in bits 5:0. Target 0 goes back to the first word.
- R10: Every other word is a no-op that advances the program counter. Each instruction that is not a ramp takes one clock.
- R11: While a channel is disabled, its program counter is held at 0 and its ramp is cancelled. Its level is kept. Re-enabling runs the kept program from word 0 on the next clock.
- R12: After reset, all levels are 0xFF, all outputs are low, the control register is 0 and all program words are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_tick | input | 1 | Counter and step-time tick strobe |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | 0 = control, 1..3 = program port of channel 0..2 |
| wr_data | input | 8 | Host write data |
| pwm_out | output | 3 | Channel outputs |
| level_mon | output | 24 | Current level of each channel, channel i at bits 8i+7:8i |

## Verification
The hardest cases to reach from the ports are the exact clocks at which a ramp steps and hands over to the next word, a disable that lands in the middle of a ramp interval, and a step interval stretched by the prescaler. The bench reaches them with short programs that end in a branch-to-self, so each channel settles in a known state. It counts clocks from the enabling write and samples the level one clock before and one clock after each predicted step. It also runs a 512-tick prescaled ramp and disables a ramp between two steps.

The output comparator is swept over all 256 levels. For each level the bench counts high cycles across a full counter period.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  localparam int WORD_W  = 16;
  localparam int LEVEL_W = 8;
  localparam int STEP_W  = 6;

  typedef enum logic [2:0] {
    OP_RESTART,
    OP_FORCE_OFF,
    OP_FORCE_ON,
    OP_LOAD,
    OP_RAMP,
    OP_BRANCH,
    OP_NOP
  } op_e;

  // ramp operand view of bits 14:0
  typedef struct packed {
    logic              prescale;
    logic [STEP_W-1:0] step_time;
    logic              down;
    logic [6:0]        steps;
  } ramp_t;

  // exact codes first, then the branch and load shapes, then ramps
  function automatic op_e decode_op(input logic [WORD_W-1:0] w);
    op_e op;
    if (w == 16'h0000)                         op = OP_RESTART;
    else if (w == 16'h007F)                    op = OP_FORCE_OFF;
    else if (w == 16'h00FF)                    op = OP_FORCE_ON;
    else if (w[15] && w[13])                   op = OP_BRANCH;
    else if (!w[15] && w[14] && w[13:8] == '0) op = OP_LOAD;
    else if (!w[15])                           op = OP_RAMP;
    else                                       op = OP_NOP;
    return op;
  endfunction

endpackage

// File: rtl/pwm_prog_store.sv
module pwm_prog_store
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ptr,
  input  logic              wr_byte,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [7:0]        hi_q, hi_d;
  logic              phase_q, phase_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              commit;

  always_comb begin
    hi_d    = hi_q;
    phase_d = phase_q;
    ptr_d   = ptr_q;
    commit  = 1'b0;
    if (clr_ptr) begin
      phase_d = 1'b0;
      ptr_d   = '0;
    end else if (wr_byte) begin
      if (!phase_q) begin
        hi_d    = wr_data;
        phase_d = 1'b1;
      end else begin
        commit  = 1'b1;
        phase_d = 1'b0;
        ptr_d   = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      phase_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      hi_q    <= hi_d;
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit) begin
      mem_q[ptr_q] <= {hi_q, wr_data};
    end
  end

  assign rd_word = mem_q[rd_addr];

  // R3: each completed word moves the pointer by one
  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr_ptr && ptr_q != PTR_W'(DEPTH-1) |=> ptr_q == $past(ptr_q) + PTR_W'(1));

  // R3: a control write leaves the loader at word 0, high byte
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> ptr_q == '0 && !phase_q);

endmodule

// File: rtl/pwm_seq_core.sv
module pwm_seq_core
  import pwm_ramp_pkg::*;
#(
  parameter int PC_W      = 6,
  parameter int PRE_SHIFT = 9,
  parameter int CNT_W     = STEP_W + PRE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [WORD_W-1:0]  instr,
  output logic [PC_W-1:0]    pc,
  output logic [LEVEL_W-1:0] level
);

  op_e                op;
  ramp_t              rf;
  logic [STEP_W-1:0]  st_eff;
  logic [PC_W-1:0]    pc_q, pc_d, pc_inc;
  logic [LEVEL_W-1:0] level_q, level_d;
  logic               ramp_q, ramp_d;
  logic               down_q, down_d;
  logic [6:0]         left_q, left_d;
  logic [CNT_W-1:0]   lim_q, lim_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  assign op     = decode_op(instr);
  assign rf     = instr[14:0];
  assign st_eff = (rf.step_time == '0) ? STEP_W'(1) : rf.step_time;
  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    pc_d    = pc_q;
    level_d = level_q;
    ramp_d  = ramp_q;
    down_d  = down_q;
    left_d  = left_q;
    lim_d   = lim_q;
    cnt_d   = cnt_q;
    if (!run) begin
      pc_d   = '0;
      ramp_d = 1'b0;
      cnt_d  = '0;
    end else if (ramp_q) begin
      if (tick) begin
        if (cnt_q == lim_q) begin
          cnt_d  = '0;
          left_d = left_q - 7'd1;
          if (down_q) level_d = (level_q == 8'h00) ? 8'h00 : level_q - 8'd1;
          else        level_d = (level_q == 8'hFF) ? 8'hFF : level_q + 8'd1;
          if (left_q == 7'd1) begin
            ramp_d = 1'b0;
            pc_d   = pc_inc;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end else begin
      case (op)
        OP_RESTART:   pc_d = '0;
        OP_FORCE_OFF: begin level_d = 8'hFF; pc_d = pc_inc; end
        OP_FORCE_ON:  begin level_d = 8'h00; pc_d = pc_inc; end
        OP_LOAD:      begin level_d = instr[7:0]; pc_d = pc_inc; end
        OP_BRANCH:    pc_d = instr[PC_W-1:0];
        OP_RAMP: begin
          if (rf.steps == '0) begin
            pc_d = pc_inc;
          end else begin
            ramp_d = 1'b1;
            down_d = rf.down;
            left_d = rf.steps;
            cnt_d  = '0;
            lim_d  = (CNT_W'(st_eff) << (rf.prescale ? PRE_SHIFT : 0)) - CNT_W'(1);
          end
        end
        default:      pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      level_q <= 8'hFF;
      ramp_q  <= 1'b0;
      down_q  <= 1'b0;
      left_q  <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
    end else begin
      pc_q    <= pc_d;
      level_q <= level_d;
      ramp_q  <= ramp_d;
      down_q  <= down_d;
      left_q  <= left_d;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pc    = pc_q;
  assign level = level_q;

  // R11: a disabled channel is rewound, idle and keeps its level
  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc_q == '0 && !ramp_q && level_q == $past(level_q));

  // R7: a ramp moves the level by at most one count per clock
  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && ramp_q |=> (level_q == $past(level_q) ||
                       level_q == $past(level_q) + 8'd1 ||
                       level_q == $past(level_q) - 8'd1));

  // R7: no fetch until the last step is spent
  assert_no_early_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && ramp_q && left_q != 7'd1 |=> pc_q == $past(pc_q));

  // R8: saturation at both end points
  assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && ramp_q && down_q && level_q == 8'h00 |=> level_q == 8'h00);
  assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && ramp_q && !down_q && level_q == 8'hFF |=> level_q == 8'hFF);

endmodule

// File: rtl/pwm_ramp_engine.sv
module pwm_ramp_engine
  import pwm_ramp_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int DEPTH     = 64,
  parameter int PRE_SHIFT = 9,
  parameter int ADDR_W    = $clog2(NCH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwm_tick,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  output logic [NCH-1:0]           pwm_out,
  output logic [NCH*LEVEL_W-1:0]   level_mon
);

  localparam int PC_W = $clog2(DEPTH);

  logic rst_meta_q, rst_sync_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_i = rst_sync_q;

  logic               ctrl_wr;
  logic [NCH-1:0]     ctrl_q, ctrl_d;
  logic [LEVEL_W-1:0] cnt_q, cnt_d;

  assign ctrl_wr = wr_en && (wr_addr == '0);

  always_comb begin
    ctrl_d = ctrl_wr  ? wr_data[NCH-1:0] : ctrl_q;
    cnt_d  = pwm_tick ? cnt_q + 8'd1     : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic               byte_wr;
    logic [PC_W-1:0]    pc_w;
    logic [WORD_W-1:0]  word_w;
    logic [LEVEL_W-1:0] lvl_w;

    assign byte_wr = wr_en && (wr_addr == ADDR_W'(i + 1));

    pwm_prog_store #(.DEPTH(DEPTH), .PTR_W(PC_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .clr_ptr (ctrl_wr),
      .wr_byte (byte_wr),
      .wr_data (wr_data),
      .rd_addr (pc_w),
      .rd_word (word_w)
    );

    pwm_seq_core #(.PC_W(PC_W), .PRE_SHIFT(PRE_SHIFT)) u_seq (
      .clk   (clk),
      .rst_n (rst_n_i),
      .run   (ctrl_q[i]),
      .tick  (pwm_tick),
      .instr (word_w),
      .pc    (pc_w),
      .level (lvl_w)
    );

    assign pwm_out[i] = ctrl_q[i] && (lvl_w != 8'hFF) && (cnt_q >= lvl_w);
    assign level_mon[i*LEVEL_W +: LEVEL_W] = lvl_w;

    // R2: the top level code never drives the output
    assert_dark_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
      lvl_w == 8'hFF |-> !pwm_out[i]);
  end

  // R1: the control register takes the written bits
  assert_ctrl_load_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    ctrl_wr |=> ctrl_q == $past(wr_data[NCH-1:0]));

  // R2: the counter wraps on a tick at the top value
  assert_counter_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    pwm_tick && cnt_q == 8'hFF |=> cnt_q == 8'h00);

endmodule

// File: tb/tb_pwm_ramp_engine.sv
`timescale 1ns/1ps
module tb_pwm_ramp_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwm_tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  pwm_out;
  logic [23:0] level_mon;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [2:0]  ctrl_sh = '0;
  logic [15:0] pbuf [8];

  always #2.5 clk = ~clk;

  pwm_ramp_engine dut (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .level_mon(level_mon)
  );

  function automatic int lvl(input int ch);
    return int'(level_mon[ch*8 +: 8]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input int ch, input bit on);
    if (on) ctrl_sh[ch] = 1'b1; else ctrl_sh[ch] = 1'b0;
    wr(2'd0, {5'd0, ctrl_sh});
  endtask

  // disable channel, load n words, enable; returns at the negedge after the enabling edge
  task automatic load_prog(input int ch, input int n);
    set_en(ch, 1'b0);
    for (int k = 0; k < n; k++) begin
      wr(2'(ch + 1), pbuf[k][15:8]);
      wr(2'(ch + 1), pbuf[k][7:0]);
    end
    set_en(ch, 1'b1);
  endtask

  task automatic count_high(input int ch, output int n);
    n = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      n += int'(pwm_out[ch]);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int n;
    int seen;
    rst_n = 1'b0; pwm_tick = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    for (int c = 0; c < 3; c++) check("R12 level after reset", lvl(c), 8'hFF);
    check("R12 outputs after reset", int'(pwm_out), 0);

    // R3: empty memory reads 0x0000 -> restart loop, level stays 0xFF
    set_en(2, 1'b1);
    repeat (10) @(negedge clk);
    check("R3 unloaded channel level", lvl(2), 8'hFF);
    count_high(2, n);
    check("R3 unloaded channel output", n, 0);
    set_en(2, 1'b0);

    // R6 + R2: sweep every level through a load, measure duty
    for (int L = 0; L < 256; L++) begin
      pbuf[0] = 16'h4000 | 16'(L); pbuf[1] = 16'hA001;
      load_prog(0, 2);
      repeat (3) @(negedge clk);
      check("R6 load level", lvl(0), L);
      count_high(0, n);
      check("R2 duty high count", n, (L == 255) ? 0 : 256 - L);
    end

    // R5 force on / off on channel 1, R1 independence
    pbuf[0] = 16'h00FF; pbuf[1] = 16'hA001;
    load_prog(1, 2);
    repeat (2) @(negedge clk);
    check("R5 force-on level", lvl(1), 8'h00);
    count_high(1, n);
    check("R5 force-on duty", n, 256);
    set_en(1, 1'b0);
    count_high(1, n);
    check("R1 disabled channel output low", n, 0);
    check("R1 other channel unaffected level", lvl(0), 8'hFF);
    pbuf[0] = 16'h007F;
    load_prog(1, 2);
    repeat (2) @(negedge clk);
    check("R5 force-off level", lvl(1), 8'hFF);
    count_high(1, n);
    check("R5 force-off duty", n, 0);
    set_en(1, 1'b0);

    // R7 ramp up, step time 2; next word after last step
    pbuf[0] = 16'h4010; pbuf[1] = 16'h0205; pbuf[2] = 16'h4077; pbuf[3] = 16'hA003;
    load_prog(0, 4);
    @(negedge clk);
    check("R7 start level", lvl(0), 8'h10);
    @(negedge clk);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R7 level between steps", lvl(0), 8'h10 + k - 1);
      @(negedge clk);
      check("R7 level at step", lvl(0), 8'h10 + k);
    end
    @(negedge clk);
    check("R7 next word after last step", lvl(0), 8'h77);

    // R8 ramp down with floor, step time 1
    pbuf[0] = 16'h4003; pbuf[1] = 16'h0186; pbuf[2] = 16'hA002;
    load_prog(0, 3);
    repeat (2) @(negedge clk);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R8 ramp down floor", lvl(0), (3 - k < 0) ? 0 : 3 - k);
    end

    // R8 ramp up with ceiling, step time field 0
    pbuf[0] = 16'h40FC; pbuf[1] = 16'h0008; pbuf[2] = 16'hA002;
    load_prog(0, 3);
    repeat (2) @(negedge clk);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R8 ramp up ceiling", lvl(0), (8'hFC + k > 255) ? 255 : 8'hFC + k);
    end

    // R7 prescaled ramp: interval 512 ticks
    pbuf[0] = 16'h4020; pbuf[1] = 16'h4102; pbuf[2] = 16'hA002;
    load_prog(0, 3);
    repeat (513) @(negedge clk);
    check("R7 prescale before first step", lvl(0), 8'h20);
    @(negedge clk);
    check("R7 prescale first step", lvl(0), 8'h21);
    repeat (511) @(negedge clk);
    check("R7 prescale before second step", lvl(0), 8'h21);
    @(negedge clk);
    check("R7 prescale second step", lvl(0), 8'h22);

    // R9 branch forward, with a stray byte cleared by the control write (R3)
    wr(2'd1, 8'hAB);
    pbuf[0] = 16'h4011; pbuf[1] = 16'hA003; pbuf[2] = 16'h4022;
    pbuf[3] = 16'h4033; pbuf[4] = 16'hA004;
    load_prog(0, 5);
    @(negedge clk);
    check("R3 first word after pointer clear", lvl(0), 8'h11);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (lvl(0) == 8'h22) seen++;
    end
    check("R9 skipped word never executed", seen, 0);
    check("R9 branch target executed", lvl(0), 8'h33);

    // R10 no-ops take one clock each
    pbuf[0] = 16'h4044; pbuf[1] = 16'h9000; pbuf[2] = 16'h8123;
    pbuf[3] = 16'h4055; pbuf[4] = 16'hA004;
    load_prog(0, 5);
    repeat (3) @(negedge clk);
    check("R10 level during no-ops", lvl(0), 8'h44);
    @(negedge clk);
    check("R10 word after two no-ops", lvl(0), 8'h55);

    // R4 restart loop: +1 every 3 clocks from kept level 0x55 (R11 keeps it)
    pbuf[0] = 16'h0001; pbuf[1] = 16'h0000;
    load_prog(0, 2);
    check("R11 level kept across disable", lvl(0), 8'h55);
    repeat (28) @(negedge clk);
    check("R4 restart loop clock 28", lvl(0), 8'h5E);
    @(negedge clk);
    check("R4 restart loop clock 29", lvl(0), 8'h5F);

    // R9 branch to 0 loops the same way
    pbuf[0] = 16'h0001; pbuf[1] = 16'hA000;
    load_prog(0, 2);
    repeat (29) @(negedge clk);
    check("R9 branch-zero loop", lvl(0), 8'h69);

    // R11 disable mid-ramp freezes, re-enable runs from word 0
    pbuf[0] = 16'h4000; pbuf[1] = 16'h0A7F;
    load_prog(0, 2);
    repeat (57) @(negedge clk);
    check("R11 ramp progress before disable", lvl(0), 5);
    set_en(0, 1'b0);
    repeat (40) @(negedge clk);
    check("R11 level frozen while disabled", lvl(0), 5);
    check("R11 output low while disabled", int'(pwm_out[0]), 0);
    set_en(0, 1'b1);
    @(negedge clk);
    check("R11 re-enable runs word 0", lvl(0), 0);

    done = 1'b1;
    finish_run();
  end

endmodule